// File: doc/BRIEF.md
# SPI Command-Word Register Access Target

This block is an SPI target, clock phase and polarity mode 0, that gives a host access to a small set of internal registers and to the head of an output queue. Each chip-select frame starts with a 16-bit command word. The word selects the transfer direction, one of eight register addresses and a transfer length. One or more 16-bit data blocks follow, in either direction.

The internal side is a 32-bit register port with single-cycle strobes and a read path that answers in the same cycle. Each 32-bit value travels as two consecutive 16-bit blocks. The order of its bytes on the wire follows a programmable word mode. Register address 7 is reserved for draining the output queue. A read to it first returns the byte length of the current item and then streams the item itself.

The serial pins are treated as synchronous to the system clock, which must run at least four times faster than SCLK. The target also reports a framing error when the host ends a frame before the transfer it announced is complete.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset `spi_miso`, `reg_wr`, `reg_rd`, `q_pop` and `frame_err` are 0. The command word is sent MSB first. Bit 15 = 1 means read and 0 means write, bits 14:12 carry the register address, and bits 11:0 carry the length. A write produces `reg_wr` with `reg_addr` equal to the command address.
- R2: The length counts 16-bit blocks. Length 0 gives a frame with no data phase and no register access. Bits sent after the announced blocks are ignored.
- R3: A read asserts `reg_rd` once per 32-bit value. The first data bit leaves on the SCLK falling edge that follows the 16th command bit, with no turnaround. `spi_miso` changes only on falling SCLK edges and is 0 while chip select is high.
- R4: For a 32-bit value with bytes B3..B0, the byte order on the wire is B1,B0,B3,B2 in mode 0 and B3,B2,B1,B0 in mode 1. Mode 2 gives B0,B1,B2,B3, and mode 3 behaves as mode 0. The same order applies to both reads and writes.
- R5: Accesses to address 0 always use mode 0, whatever `cfg_word_mode` holds.
- R6: A read of address 7 ignores the length field. It returns `q_len` as the first block, then ceil(`q_len`/2) blocks of queue data, taking each 32-bit item word with one `q_pop` and ordering it by the word mode.
- R7: A write to address 7 consumes its data blocks but never asserts `reg_wr`.
- R8: With an odd length, the last unpaired write block causes no register write. An odd-length read ends after the first half of its last 32-bit value.
- R9: If chip select rises after at least one SCLK rising edge but before the last announced block completes, `frame_err` pulses for one cycle.
- R10: When `cfg_frm_chk_off` is 1, no framing error is reported. Chip select rising still returns the decoder to waiting for a command word.
- R11: A frame that completes, or that has no SCLK edge at all, ends without `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| cfg_word_mode | input | 2 | Byte-order mode for addresses other than 0 |
| cfg_frm_chk_off | input | 1 | 1 disables the framing-error check |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 3 | Register address of the current access |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register read value, valid in the `reg_rd` cycle |
| q_len | input | 16 | Byte length of the current output-queue item |
| q_data | input | 32 | Current queue data word, valid in the `q_pop` cycle |
| q_pop | output | 1 | Advance the queue by one 32-bit word |
| frame_err | output | 1 | One-cycle framing-error pulse |

## Verification
Several events can fall in the same system-clock cycle. The rising SCLK edge that completes a data block also triggers the register or queue strobe and the load of the next transmit word. At chip-select rise, the framing decision is made in the same cycle as the decoder reset. The bench provokes both. It stops frames in the middle of the command and in the middle of the data, and also right after a transfer completes. It then counts strobes and framing pulses against a behavioural host model. Each received block is compared with the byte order the model derives for the mode in force.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the SPI command-word register target.
package spi_cmd_pkg;

    // Sequencer phase within one chip-select frame.
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // Byte-order modes for a 32-bit value carried as two blocks.
    localparam logic [1:0] WM_LOWFIRST  = 2'd0;
    localparam logic [1:0] WM_HIGHFIRST = 2'd1;
    localparam logic [1:0] WM_BYTEREV   = 2'd2;

endpackage

// File: rtl/spi_cmd_shift.sv
// Serial front end: detects SCLK edges on the system clock and shifts
// MOSI into a receive word, MSB first. It also shifts a loaded transmit
// word onto MISO, driving one bit on each falling SCLK edge.
// Assumes SCLK/CS/MOSI are synchronous to clk and that clk runs at
// least 4x faster than SCLK. Mode 0: SCLK idles low.
module spi_cmd_shift #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic          tx_load,
    input  logic [BW-1:0] tx_word,
    output logic          rise,
    output logic          word_done,
    output logic [BW-1:0] rx_word,
    output logic          miso
);
    localparam int CW = $clog2(BW);

    logic          sclk_q;
    logic          fall;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] rx_sh;
    logic [BW-1:0] tx_sh;

    // Edge strobes, qualified by chip select.
    always_comb begin
        rise      = !cs_n && sclk && !sclk_q;
        fall      = !cs_n && !sclk && sclk_q;
        word_done = rise && (bit_cnt == CW'(BW - 1));
        rx_word   = {rx_sh[BW-2:0], mosi};
    end

    // Previous SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Receive shifter and bit counter, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sh   <= rx_word;
        end
    end

    // Transmit shifter and MISO register, updated on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            tx_sh <= '0;
            miso  <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_word;
        end else if (fall) begin
            miso  <= tx_sh[BW-1];
            tx_sh <= {tx_sh[BW-2:0], 1'b0};
        end
    end

    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !fall) |=> $stable(miso)); // R3
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (miso == 1'b0)); // R3

endmodule

// File: rtl/spi_cmd_lanes.sv
// Byte-lane ordering between one 32-bit value and its two 16-bit wire
// blocks (first block sent first). Purely combinational. Split serves
// reads and merge serves writes. Mode 3 falls back to mode 0.
module spi_cmd_lanes
    import spi_cmd_pkg::*;
#(
    parameter int BW = 16
) (
    input  logic [1:0]      mode,
    input  logic [2*BW-1:0] split_in,
    output logic [BW-1:0]   split_first,
    output logic [BW-1:0]   split_second,
    input  logic [BW-1:0]   merge_first,
    input  logic [BW-1:0]   merge_second,
    output logic [2*BW-1:0] merge_out
);
    localparam int HB = BW / 2;

    // Swap the two bytes of one block.
    function automatic logic [BW-1:0] swap_b(input logic [BW-1:0] w);
        return {w[HB-1:0], w[BW-1:HB]};
    endfunction

    // Value to wire blocks.
    always_comb begin
        unique case (mode)
            WM_HIGHFIRST: begin
                split_first  = split_in[2*BW-1:BW];
                split_second = split_in[BW-1:0];
            end
            WM_BYTEREV: begin
                split_first  = swap_b(split_in[BW-1:0]);
                split_second = swap_b(split_in[2*BW-1:BW]);
            end
            default: begin
                split_first  = split_in[BW-1:0];
                split_second = split_in[2*BW-1:BW];
            end
        endcase
    end

    // Wire blocks to value.
    always_comb begin
        unique case (mode)
            WM_HIGHFIRST: merge_out = {merge_first, merge_second};
            WM_BYTEREV:   merge_out = {swap_b(merge_second), swap_b(merge_first)};
            default:      merge_out = {merge_second, merge_first};
        endcase
    end

endmodule

// File: rtl/spi_cmd_seq.sv
// Command decoder and block sequencer. It decodes the command word,
// counts data blocks and raises register/queue strobes at block
// boundaries. It also picks the next transmit block and judges framing
// when chip select rises. Assumes reg_rdata/q_data answer combinationally
// in the strobe cycle and that q_len is stable while the command ends.
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int BW  = 16,
    parameter int AW  = 3,
    parameter int LW  = 12,
    parameter int QLW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rise,
    input  logic            word_done,
    input  logic [BW-1:0]   rx_word,
    input  logic [1:0]      cfg_mode,
    input  logic            cfg_frm_off,
    output logic            tx_load,
    output logic [BW-1:0]   tx_word,
    output logic            reg_wr,
    output logic            reg_rd,
    output logic [AW-1:0]   reg_addr,
    output logic [2*BW-1:0] reg_wdata,
    input  logic [2*BW-1:0] reg_rdata,
    input  logic [QLW-1:0]  q_len,
    input  logic [2*BW-1:0] q_data,
    output logic            q_pop,
    output logic            frame_err
);
    localparam int TW = QLW + 1;
    localparam logic [AW-1:0] QADDR = '1;
    localparam logic [AW-1:0] CADDR = '0;

    phase_t        phase_q;
    logic          started_q, cs_q, is_rd_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    mode_q;
    logic [TW-1:0] total_q, blk_q;
    logic [BW-1:0] hold_q;

    logic          in_cmd, in_data, cmd_rd, cur_rd, cur_is_q;
    logic [AW-1:0] cmd_addr, cur_addr;
    logic [1:0]    cmd_mode, cur_mode;
    logic [TW-1:0] cmd_total, cur_total, nb;
    logic          load_ok, fresh, len_slot, wr_ok;
    logic [BW-1:0] sp_first, sp_second;

    // Command fields and the view that is current in this cycle.
    always_comb begin
        in_cmd    = word_done && (phase_q == PH_CMD);
        in_data   = word_done && (phase_q == PH_DATA);
        cmd_rd    = rx_word[BW-1];
        cmd_addr  = rx_word[BW-2 -: AW];
        cmd_mode  = (cmd_addr == CADDR) ? WM_LOWFIRST : cfg_mode;
        cmd_total = (cmd_rd && cmd_addr == QADDR)
                  ? TW'(1) + ((TW'(q_len) + TW'(1)) >> 1)
                  : TW'(rx_word[LW-1:0]);
        cur_rd    = (phase_q == PH_CMD) ? cmd_rd    : is_rd_q;
        cur_addr  = (phase_q == PH_CMD) ? cmd_addr  : addr_q;
        cur_mode  = (phase_q == PH_CMD) ? cmd_mode  : mode_q;
        cur_total = (phase_q == PH_CMD) ? cmd_total : total_q;
        cur_is_q  = cur_rd && (cur_addr == QADDR);
    end

    // Read-side block selection and strobes.
    always_comb begin
        nb       = in_cmd ? '0 : blk_q + 1'b1;
        load_ok  = (in_cmd || in_data) && cur_rd && (nb < cur_total);
        fresh    = cur_is_q ? nb[0] : !nb[0];
        len_slot = cur_is_q && (nb == '0);
        tx_load  = load_ok;
        tx_word  = len_slot ? BW'(q_len) : (fresh ? sp_first : hold_q);
        reg_rd   = load_ok && fresh && !cur_is_q;
        q_pop    = load_ok && fresh && cur_is_q;
        reg_addr = cur_addr;
    end

    // Write-side strobe on the second block of each pair.
    always_comb begin
        wr_ok  = in_data && !is_rd_q;
        reg_wr = wr_ok && blk_q[0] && (addr_q != QADDR);
    end

    spi_cmd_lanes #(.BW(BW)) u_lanes (
        .mode         (cur_mode),
        .split_in     (cur_is_q ? q_data : reg_rdata),
        .split_first  (sp_first),
        .split_second (sp_second),
        .merge_first  (hold_q),
        .merge_second (rx_word),
        .merge_out    (reg_wdata)
    );

    // Frame sequencing: command latch, block count, done detection.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase_q   <= PH_CMD;
            started_q <= 1'b0;
            is_rd_q   <= 1'b0;
            addr_q    <= '0;
            mode_q    <= WM_LOWFIRST;
            total_q   <= '0;
            blk_q     <= '0;
        end else begin
            if (rise) started_q <= 1'b1;
            if (in_cmd) begin
                is_rd_q <= cmd_rd;
                addr_q  <= cmd_addr;
                mode_q  <= cmd_mode;
                total_q <= cmd_total;
                blk_q   <= '0;
                phase_q <= (cmd_total == '0) ? PH_DONE : PH_DATA;
            end else if (in_data) begin
                blk_q <= blk_q + 1'b1;
                if (blk_q + 1'b1 == total_q) phase_q <= PH_DONE;
            end
        end
    end

    // Half-value holding register shared by reads and writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (load_ok && fresh)   hold_q <= sp_second;
        else if (wr_ok && !blk_q[0]) hold_q <= rx_word;
    end

    // Framing judgement on the chip-select rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q      <= 1'b1;
            frame_err <= 1'b0;
        end else begin
            cs_q      <= cs_n;
            frame_err <= cs_n && !cs_q && started_q &&
                         (phase_q != PH_DONE) && !cfg_frm_off;
        end
    end

    AST_WR_SKIPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr != QADDR)); // R7
    AST_POP_ONLY_QREAD: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (reg_addr == QADDR && !reg_wr && !reg_rd)); // R6
    AST_RD_NOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !reg_wr); // R3
    AST_ERR_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($past(cs_n) && !$past(cs_n, 2))); // R9
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !$past(cfg_frm_off)); // R10

endmodule

// File: rtl/spi_cmd_slave.sv
// Top level of the SPI command-word register target. It joins the serial
// front end to the command sequencer. Assumes synchronous serial pins
// sampled by clk, and a register/queue port that answers in the strobe cycle.
module spi_cmd_slave #(
    parameter int BW  = 16,
    parameter int AW  = 3,
    parameter int LW  = 12,
    parameter int QLW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_cs_n,
    input  logic            spi_mosi,
    output logic            spi_miso,
    input  logic [1:0]      cfg_word_mode,
    input  logic            cfg_frm_chk_off,
    output logic            reg_wr,
    output logic            reg_rd,
    output logic [AW-1:0]   reg_addr,
    output logic [2*BW-1:0] reg_wdata,
    input  logic [2*BW-1:0] reg_rdata,
    input  logic [QLW-1:0]  q_len,
    input  logic [2*BW-1:0] q_data,
    output logic            q_pop,
    output logic            frame_err
);
    logic          rise, word_done, tx_load;
    logic [BW-1:0] rx_word, tx_word;

    spi_cmd_shift #(.BW(BW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_load   (tx_load),
        .tx_word   (tx_word),
        .rise      (rise),
        .word_done (word_done),
        .rx_word   (rx_word),
        .miso      (spi_miso)
    );

    spi_cmd_seq #(.BW(BW), .AW(AW), .LW(LW), .QLW(QLW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (spi_cs_n),
        .rise        (rise),
        .word_done   (word_done),
        .rx_word     (rx_word),
        .cfg_mode    (cfg_word_mode),
        .cfg_frm_off (cfg_frm_chk_off),
        .tx_load     (tx_load),
        .tx_word     (tx_word),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .q_len       (q_len),
        .q_data      (q_data),
        .q_pop       (q_pop),
        .frame_err   (frame_err)
    );

endmodule

// File: tb/spi_cmd_slave_tb.sv
// Bench: a behavioural SPI host and register/queue model, with every
// expected value derived from the requirements.
module spi_cmd_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        spi_miso;
    logic [1:0]  mode = 2'd0;
    logic        frm_off = 1'b0;
    logic        reg_wr, reg_rd, q_pop, frame_err;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, q_data;
    logic [15:0] q_len = 16'd5;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, pop_cnt = 0, ferr_cnt = 0, qidx = 0;
    logic [2:0]  last_wa;
    logic [31:0] last_wd;
    logic        cs_d = 1'b1, cs_d2 = 1'b1;
    logic [15:0] tx_blk [0:7];
    logic [15:0] rx_blk [0:7];

    always #2 clk = ~clk;

    // Register contents: bytes A_, B_, C_, D_ with the address in the low nibble.
    function automatic logic [31:0] regv(input logic [2:0] a);
        return {8'hA0 | 8'(a), 8'hB0 | 8'(a), 8'hC0 | 8'(a), 8'hD0 | 8'(a)};
    endfunction
    function automatic logic [31:0] qword(input int i);
        return {8'h10 + 8'(i), 8'h20 + 8'(i), 8'h30 + 8'(i), 8'h40 + 8'(i)};
    endfunction
    // Wire block k (0 first) of a value under a byte-order mode.
    function automatic logic [15:0] wblk(input logic [31:0] v, input logic [1:0] m, input int k);
        logic [7:0] b0, b1, b2, b3;
        {b3, b2, b1, b0} = v;
        case (m)
            2'd1:    return (k == 0) ? {b3, b2} : {b1, b0};
            2'd2:    return (k == 0) ? {b0, b1} : {b2, b3};
            default: return (k == 0) ? {b1, b0} : {b3, b2};
        endcase
    endfunction

    assign reg_rdata = regv(reg_addr);
    assign q_data    = qword(qidx);

    spi_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(spi_miso), .cfg_word_mode(mode),
        .cfg_frm_chk_off(frm_off), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .q_len(q_len), .q_data(q_data), .q_pop(q_pop), .frame_err(frame_err)
    );

    // Model-side event log, sampled at each clock.
    always @(posedge clk) begin
        cs_d  <= cs_n;
        cs_d2 <= cs_d;
        if (rst_n) begin
            if (reg_wr) begin wr_cnt <= wr_cnt + 1; last_wa <= reg_addr; last_wd <= reg_wdata; end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
            if (q_pop) begin pop_cnt <= pop_cnt + 1; qidx <= qidx + 1; end
            if (frame_err) ferr_cnt <= ferr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison: a deselected target keeps MISO at 0 (R3).
    always @(negedge clk) begin
        if (rst_n && cs_d && cs_d2) chk("R3 miso idle", {31'd0, spi_miso}, 32'd0);
    end

    // One SPI mode-0 frame. abort_at >= 0 raises CS after that many bits.
    task automatic xfer(input logic [15:0] cmd, input int nblk, input int abort_at);
        int nbits;
        logic [15:0] w;
        nbits = 16 * (1 + nblk);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (abort_at >= 0 && i == abort_at) break;
            w = (i < 16) ? cmd : tx_blk[(i - 16) / 16];
            sclk = 1'b0;
            mosi = w[15 - (i % 16)];
            repeat (3) @(negedge clk);
            if (i >= 16) rx_blk[(i - 16) / 16][15 - (i % 16)] = spi_miso;
            @(negedge clk) sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    int w0, r0, p0, f0, q0;
    task automatic snap;
        w0 = wr_cnt; r0 = rd_cnt; p0 = pop_cnt; f0 = ferr_cnt; q0 = qidx;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset miso", {31'd0, spi_miso}, 32'd0);
        chk("R1 reset strobes", {28'd0, reg_wr, reg_rd, q_pop, frame_err}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1/R4 mode 0 write to address 3.
        mode = 2'd0; snap();
        tx_blk[0] = wblk(32'h3344_1122, 2'd0, 0); tx_blk[1] = wblk(32'h3344_1122, 2'd0, 1);
        xfer(16'h3002, 2, -1);
        chk("R1 write count", 32'(wr_cnt - w0), 32'd1);
        chk("R1 write addr", {29'd0, last_wa}, 32'd3);
        chk("R4 mode0 write", last_wd, 32'h3344_1122);
        chk("R11 no err on full frame", 32'(ferr_cnt - f0), 32'd0);

        // R4 mode 1 write.
        mode = 2'd1; snap();
        tx_blk[0] = wblk(32'hAABB_CCDD, 2'd1, 0); tx_blk[1] = wblk(32'hAABB_CCDD, 2'd1, 1);
        xfer(16'h5002, 2, -1);
        chk("R4 mode1 write", last_wd, 32'hAABB_CCDD);

        // R4 mode 2 write.
        mode = 2'd2; snap();
        tx_blk[0] = wblk(32'h0403_0201, 2'd2, 0); tx_blk[1] = wblk(32'h0403_0201, 2'd2, 1);
        xfer(16'h2002, 2, -1);
        chk("R4 mode2 write", last_wd, 32'h0403_0201);

        // R4 mode 3 behaves as mode 0.
        mode = 2'd3; snap();
        tx_blk[0] = wblk(32'h9988_7766, 2'd0, 0); tx_blk[1] = wblk(32'h9988_7766, 2'd0, 1);
        xfer(16'h1002, 2, -1);
        chk("R4 mode3 write", last_wd, 32'h9988_7766);

        // R5 address 0 write forces mode 0.
        mode = 2'd1; snap();
        tx_blk[0] = wblk(32'h7788_5566, 2'd0, 0); tx_blk[1] = wblk(32'h7788_5566, 2'd0, 1);
        xfer(16'h0002, 2, -1);
        chk("R5 cfg write order", last_wd, 32'h7788_5566);
        chk("R5 cfg write addr", {29'd0, last_wa}, 32'd0);

        // R3/R4 mode 2 read of address 4.
        mode = 2'd2; snap();
        xfer(16'hC002, 2, -1);
        chk("R3 read strobes", 32'(rd_cnt - r0), 32'd1);
        chk("R3 R4 read blk0 no turnaround", {16'd0, rx_blk[0]}, {16'd0, wblk(regv(3'd4), 2'd2, 0)});
        chk("R4 read blk1", {16'd0, rx_blk[1]}, {16'd0, wblk(regv(3'd4), 2'd2, 1)});

        // R5 read of address 0 in mode 1 still uses mode 0.
        mode = 2'd1; snap();
        xfer(16'h8002, 2, -1);
        chk("R5 cfg read blk0", {16'd0, rx_blk[0]}, {16'd0, wblk(regv(3'd0), 2'd0, 0)});
        chk("R5 cfg read blk1", {16'd0, rx_blk[1]}, {16'd0, wblk(regv(3'd0), 2'd0, 1)});

        // R2 zero length and trailing extra bits.
        snap();
        xfer(16'h6000, 0, -1);
        chk("R2 len0 no access", 32'(wr_cnt - w0), 32'd0);
        chk("R2 len0 no err", 32'(ferr_cnt - f0), 32'd0);
        mode = 2'd0; snap();
        tx_blk[0] = 16'h0102; tx_blk[1] = 16'h0304; tx_blk[2] = 16'hFFFF;
        xfer(16'h1002, 3, -1);
        chk("R2 extra bits ignored", 32'(wr_cnt - w0), 32'd1);
        chk("R2 extra value", last_wd, 32'h0304_0102);
        chk("R2 extra no err", 32'(ferr_cnt - f0), 32'd0);

        // R8 odd-length write and read.
        snap();
        tx_blk[0] = 16'h1111; tx_blk[1] = 16'h2222; tx_blk[2] = 16'h3333;
        xfer(16'h2003, 3, -1);
        chk("R8 odd write count", 32'(wr_cnt - w0), 32'd1);
        chk("R8 odd write value", last_wd, 32'h2222_1111);
        snap();
        xfer(16'hE001, 1, -1);
        chk("R8 odd read strobes", 32'(rd_cnt - r0), 32'd1);
        chk("R8 odd read blk", {16'd0, rx_blk[0]}, {16'd0, wblk(regv(3'd6), 2'd0, 0)});
        chk("R8 odd read no err", 32'(ferr_cnt - f0), 32'd0);

        // R6 queue read: length first, then data, mode 1.
        mode = 2'd1; q_len = 16'd5; snap();
        xfer(16'hF000, 4, -1);
        chk("R6 length block", {16'd0, rx_blk[0]}, 32'd5);
        chk("R6 data blk1", {16'd0, rx_blk[1]}, {16'd0, wblk(qword(q0), 2'd1, 0)});
        chk("R6 data blk2", {16'd0, rx_blk[2]}, {16'd0, wblk(qword(q0), 2'd1, 1)});
        chk("R6 data blk3", {16'd0, rx_blk[3]}, {16'd0, wblk(qword(q0 + 1), 2'd1, 0)});
        chk("R6 pops", 32'(pop_cnt - p0), 32'd2);
        chk("R6 no reg read", 32'(rd_cnt - r0), 32'd0);
        chk("R6 no err", 32'(ferr_cnt - f0), 32'd0);

        // R7 write to the queue address.
        snap();
        tx_blk[0] = 16'hDEAD; tx_blk[1] = 16'hBEEF;
        xfer(16'h7002, 2, -1);
        chk("R7 no reg write", 32'(wr_cnt - w0), 32'd0);
        chk("R7 no err", 32'(ferr_cnt - f0), 32'd0);

        // R9 early deselect in data and in command.
        mode = 2'd0; snap();
        xfer(16'hB002, 2, 20);
        chk("R9 abort in data", 32'(ferr_cnt - f0), 32'd1);
        snap();
        xfer(16'h3002, 2, 8);
        chk("R9 abort in command", 32'(ferr_cnt - f0), 32'd1);
        chk("R9 no write on abort", 32'(wr_cnt - w0), 32'd0);

        // R10 check disabled, then decoder idle for a new command.
        frm_off = 1'b1; snap();
        xfer(16'h3002, 2, 24);
        chk("R10 no err when off", 32'(ferr_cnt - f0), 32'd0);
        snap();
        tx_blk[0] = 16'h5A5A; tx_blk[1] = 16'hA5A5;
        xfer(16'h4002, 2, -1);
        chk("R10 next command count", 32'(wr_cnt - w0), 32'd1);
        chk("R10 next command addr", {29'd0, last_wa}, 32'd4);
        chk("R10 next command value", last_wd, 32'hA5A5_5A5A);
        frm_off = 1'b0;

        // R11 frame with no SCLK edges.
        snap();
        xfer(16'h3002, 2, 0);
        chk("R11 empty frame", 32'(ferr_cnt - f0), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule